// File: doc/BRIEF.md
# Fractional-Increment Real-Time Counter

This block keeps a 64-bit free-running count that advances at one fixed nominal rate (6.144 MHz) no matter which reference frequency clocks it. A fraction of the reference rate sets the pace of the count, and it is held as a numerator and a denominator, each 12 bits wide. On every reference edge an internal remainder grows by the numerator. When the remainder reaches the denominator, the denominator is taken off and the count steps by one. The count therefore advances exactly `numerator` times in every `denominator` reference cycles.

Software programs the two terms through a small register port: offset 0x10 holds the numerator and offset 0x14 holds the denominator. Typical settings are 4/25 for 38.4 MHz (the reset default), 8/25 for 19.2 MHz, 64/125 for 12 MHz, 768/1625 for 13 MHz, 384/1625 for 26 MHz and 256/1125 for 27 MHz. A write to either term restarts the fractional phase from zero.

Top module: `frt_top`

## Requirements
- R1: After reset, `count` is 0. The numerator reads back as 4 and the denominator as 25.
- R2: A write to offset 0x10 loads `cfg_wdata[11:0]` into the numerator. A read of 0x10 returns the value in bits [11:0] and zero in bits [31:12], whatever was written to those upper bits.
- R3: A write to offset 0x14 loads `cfg_wdata[11:0]` into the denominator. A read of 0x14 returns the value in bits [11:0] and zero in bits [31:12].
- R4: A write to any other offset changes neither term and does not disturb counting. A read of any other offset returns 0.
- R5: On each clock edge without a register write, the remainder grows by the numerator. If the sum is at least the denominator, the denominator is subtracted and `count` increases by exactly one on that edge. Otherwise `count` holds.
- R6: When the numerator is below the denominator, `count` advances by exactly the numerator over the denominator's worth of clocks that follow a write.
- R7: On an edge that writes offset 0x10 or 0x14, the remainder clears to zero and `count` does not step.
- R8: When the numerator is at least the denominator (a denominator of zero included), `count` steps on every clock edge that carries no write, and the remainder stays at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset for both read and write |
| cfg_wdata | input | 32 | Write data; only bits [11:0] are kept |
| cfg_rdata | output | 32 | Combinational read data for `cfg_addr` |
| count | output | 64 | Real-time count value |

## Verification
A register write can land on the very edge where the remainder would cross the denominator, so the clear and the step compete in one cycle. The bench provokes this by setting 24/25 and rewriting the denominator every second cycle: each write falls on the edge that would otherwise step. The count must then stay frozen, and a lockstep model checks every cycle that the write wins. Exact advance over a full denominator window is judged separately for each reference ratio.

// File: rtl/frt_pkg.sv
package frt_pkg;
  localparam int FRAC_W = 12;

  typedef logic [FRAC_W-1:0] frac_t;

  typedef struct packed {
    frac_t acc;
    logic  step;
  } frac_res_t;

  // One reference edge of the fractional rate generator.
  function automatic frac_res_t frac_advance(frac_t acc, frac_t num, frac_t den);
    logic [FRAC_W:0] sum;
    frac_res_t r;
    sum = {1'b0, acc} + {1'b0, num};
    if (num >= den) begin
      r.acc  = '0;
      r.step = 1'b1;
    end else if (sum >= {1'b0, den}) begin
      r.acc  = frac_t'(sum - {1'b0, den});
      r.step = 1'b1;
    end else begin
      r.acc  = sum[FRAC_W-1:0];
      r.step = 1'b0;
    end
    return r;
  endfunction

  // Register read image: value in the low field, zero above.
  function automatic logic [31:0] frac_image(frac_t v);
    return {{(32-FRAC_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/frt_cfg_regs.sv
module frt_cfg_regs
  import frt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] OFS_NUM = 8'h10,
  parameter logic [ADDR_W-1:0] OFS_DEN = 8'h14,
  parameter int DEF_NUM = 4,
  parameter int DEF_DEN = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output frac_t             num_q,
  output frac_t             den_q,
  output logic              wr_hit
);
  logic wr_num, wr_den;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^wdata[31:FRAC_W];
  assign wr_num = wr && (addr == OFS_NUM);
  assign wr_den = wr && (addr == OFS_DEN);
  assign wr_hit = wr_num || wr_den;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      num_q <= frac_t'(DEF_NUM);
      den_q <= frac_t'(DEF_DEN);
    end else begin
      if (wr_num) num_q <= wdata[FRAC_W-1:0];
      if (wr_den) den_q <= wdata[FRAC_W-1:0];
    end
  end

  always_comb begin
    if (addr == OFS_NUM)      rdata = frac_image(num_q);
    else if (addr == OFS_DEN) rdata = frac_image(den_q);
    else                      rdata = '0;
  end
endmodule

// File: rtl/frt_frac_accum.sv
module frt_frac_accum
  import frt_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  frac_t num,
  input  frac_t den,
  output logic  step,
  output frac_t acc_q
);
  frac_res_t nxt;

  always_comb begin
    nxt  = frac_advance(acc_q, num, den);
    step = nxt.step && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else          acc_q <= nxt.acc;
  end
endmodule

// File: rtl/frt_tick_counter.sv
module frt_tick_counter #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    count <= '0;
    else if (step) count <= count + CNT_W'(1);
  end
endmodule

// File: rtl/frt_top.sv
module frt_top
  import frt_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int ADDR_W  = 8,
  parameter int DEF_NUM = 4,
  parameter int DEF_DEN = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic [CNT_W-1:0]  count
);
  frac_t num_q, den_q, acc_q;
  logic  wr_hit, step;

  frt_cfg_regs #(
    .ADDR_W (ADDR_W),
    .OFS_NUM(ADDR_W'(8'h10)),
    .OFS_DEN(ADDR_W'(8'h14)),
    .DEF_NUM(DEF_NUM),
    .DEF_DEN(DEF_DEN)
  ) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr    (cfg_wr),
    .addr  (cfg_addr),
    .wdata (cfg_wdata),
    .rdata (cfg_rdata),
    .num_q (num_q),
    .den_q (den_q),
    .wr_hit(wr_hit)
  );

  frt_frac_accum u_accum (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (wr_hit),
    .num  (num_q),
    .den  (den_q),
    .step (step),
    .acc_q(acc_q)
  );

  frt_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .step (step),
    .count(count)
  );
endmodule

// File: rtl/frt_top_chk.sv
module frt_top_chk
  import frt_pkg::*;
#(
  parameter int CNT_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] count,
  input logic             step,
  input logic             wr_hit,
  input frac_t            acc_q,
  input frac_t            num_q,
  input frac_t            den_q
);
  AST_RESET_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (count == '0)); // R1

  AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (count == $past(count) + CNT_W'(1))); // R5

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count)); // R5

  AST_REMAINDER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q == '0) || (acc_q < den_q)); // R5

  AST_WRITE_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> ($stable(count) && acc_q == '0)); // R7

  AST_FAST_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (num_q >= den_q && !wr_hit) |=> (count == $past(count) + CNT_W'(1))); // R8
endmodule

bind frt_top frt_top_chk #(.CNT_W(CNT_W)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .count (count),
  .step  (step),
  .wr_hit(wr_hit),
  .acc_q (acc_q),
  .num_q (num_q),
  .den_q (den_q)
);

// File: tb/frt_top_test.sv
`timescale 1ns/1ps
module frt_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [63:0] count;

  frt_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .count(count)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [63:0] cnt;
    string       tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int fails = 0;
  longint unsigned m_cnt = 0;
  int m_num = 4, m_den = 25, m_acc = 0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus, advances the reference model
  // and queues the count expected after that edge. Starts and ends at negedge.
  task automatic drive(bit wr, logic [7:0] a, logic [31:0] d, string tag,
                       bit rd = 1'b0, logic [31:0] erd = '0);
    cfg_wr = wr; cfg_addr = a; cfg_wdata = d;
    if (rd) begin
      #1;
      check(tag, {32'd0, cfg_rdata}, {32'd0, erd});
    end
    @(posedge clk);
    if (wr && a == 8'h10) begin
      m_num = int'(d[11:0]); m_acc = 0;
    end else if (wr && a == 8'h14) begin
      m_den = int'(d[11:0]); m_acc = 0;
    end else if (m_num >= m_den) begin
      m_cnt++; m_acc = 0;
    end else begin
      m_acc = m_acc + m_num;
      if (m_acc >= m_den) begin
        m_acc = m_acc - m_den; m_cnt++;
      end
    end
    q.push_back('{m_cnt, tag});
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 8'h00, '0, tag);
  endtask

  // R6: exact advance over one denominator window after programming.
  task automatic rate(int num, int den, string tag);
    logic [63:0] c0;
    drive(1'b1, 8'h10, 32'(num), tag);
    drive(1'b1, 8'h14, 32'(den), tag);
    c0 = count;
    idle(den, tag);
    check(tag, count - c0, 64'(num));
  endtask

  // Monitor: compares the design with queued expectations after each edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, count, e.cnt);
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] c0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 count after reset", count, 64'd0);
    drive(1'b0, 8'h10, '0, "R1 numerator default", 1'b1, 32'd4);
    drive(1'b0, 8'h14, '0, "R1 denominator default", 1'b1, 32'd25);
    idle(60, "R5 default ratio");

    drive(1'b1, 8'h10, 32'hABCD_E008, "R2 numerator write");
    drive(1'b0, 8'h10, '0, "R2 numerator readback", 1'b1, 32'h0000_0008);
    drive(1'b1, 8'h14, 32'h1234_5019, "R3 denominator write");
    drive(1'b0, 8'h14, '0, "R3 denominator readback", 1'b1, 32'h0000_0019);
    idle(40, "R5 ratio 8/25");

    rate(8, 25, "R6 ratio 8/25");
    rate(4, 25, "R6 ratio 4/25");
    rate(64, 125, "R6 ratio 64/125");
    rate(768, 1625, "R6 ratio 768/1625");
    rate(384, 1625, "R6 ratio 384/1625");
    rate(256, 1125, "R6 ratio 256/1125");

    drive(1'b1, 8'h18, 32'h0000_0FFF, "R4 write other offset");
    drive(1'b1, 8'h11, 32'h0000_0001, "R4 write near offset");
    drive(1'b0, 8'h10, '0, "R4 numerator unchanged", 1'b1, 32'd256);
    drive(1'b0, 8'h14, '0, "R4 denominator unchanged", 1'b1, 32'd1125);
    drive(1'b0, 8'h18, '0, "R4 unmapped read", 1'b1, 32'd0);
    idle(20, "R4 counting continues");

    drive(1'b1, 8'h10, 32'd24, "R7 setup");
    drive(1'b1, 8'h14, 32'd25, "R7 setup");
    c0 = count;
    for (int i = 0; i < 20; i++) begin
      drive(1'b0, 8'h00, '0, "R7 between writes");
      drive(1'b1, 8'h14, 32'd25, "R7 write on crossing edge");
    end
    check("R7 count frozen by writes", count - c0, 64'd0);

    drive(1'b1, 8'h10, 32'd30, "R8 setup");
    c0 = count;
    idle(10, "R8 numerator above denominator");
    check("R8 steps every clock 30/25", count - c0, 64'd10);
    drive(1'b1, 8'h14, 32'd30, "R8 setup equal");
    c0 = count;
    idle(10, "R8 numerator equals denominator");
    check("R8 steps every clock 30/30", count - c0, 64'd10);
    drive(1'b1, 8'h14, 32'd0, "R8 setup zero");
    c0 = count;
    idle(10, "R8 zero denominator");
    check("R8 steps every clock den 0", count - c0, 64'd10);

    rate(4, 25, "R6 restore default");
    idle(3, "R5 tail");
    #3;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule